// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure held in memory. A requester presents the address together with a write flag and a user/supervisor flag. The walker reads the first-level (directory) entry, then the second-level (table) entry, over a single 32-bit memory port. It checks the present, user and writable flags of both levels. On success it writes updated accessed and dirty flags back to memory, then returns the physical address. Otherwise it returns a page fault with an exact error code and latches the faulting linear address.

A directory base register and an enable bit sit in the block. Writing either of them produces a one-cycle flush pulse for any downstream translation cache. When translation is disabled, addresses pass straight through without touching memory. A static input selects how the two user flags combine.

The controller is one state machine. Its states are `ST_IDLE` (accept a request), `ST_DIR_RD` (read the directory entry), `ST_TBL_RD` (read the table entry and judge the access), `ST_DIR_WB` (write back the directory entry), `ST_TBL_WB` (write back the table entry) and `ST_RESP` (one-cycle result). Its transitions are:

- IDLE→RESP when a request is accepted with translation off.
- IDLE→DIR_RD when a request is accepted with translation on.
- DIR_RD→RESP on a directory not-present fault.
- DIR_RD→TBL_RD otherwise.
- TBL_RD→RESP on a fault, or on success when nothing needs updating.
- TBL_RD→DIR_WB when the directory accessed flag is clear.
- TBL_RD→TBL_WB when only the table entry needs an update.
- DIR_WB→TBL_WB or DIR_WB→RESP, depending on whether the table entry still needs an update.
- TBL_WB→RESP.
- RESP→IDLE.

Top module: `pt_walker`

## Requirements
- R1: The linear address splits into directory index [31:22], table index [21:12] and offset [11:0]. The directory entry is read at base[31:12]·4096 + dir_index·4. The table entry is read at dir_entry[31:12]·4096 + table_index·4. The physical address is table_entry[31:12] concatenated with the offset.
- R2: If an entry's present flag (bit 0) is clear, the result is a fault with rsp_err = {user, write, 0}, where bit 2 is user and bit 1 is write. A non-present directory entry causes exactly one memory read.
- R3: A privilege fault reports rsp_err = 3'b101 with bit 1 set for a write. Privilege faults happen only for user accesses; supervisor accesses ignore the user (bit 2) and writable (bit 1) flags.
- R4: With user_rule=0, a user access is denied only when both user flags are clear. With user_rule=1, it is denied when either user flag is clear.
- R5: A user write is denied when either writable flag is clear.
- R6: Every fault loads fault_addr with the faulting linear address. A successful translation leaves fault_addr unchanged.
- R7: On success, a directory entry with accessed (bit 5) clear is written back with bit 5 set, before any table write-back. A table entry is written back as entry|0x20|(write ? 0x40 : 0) when its accessed flag is clear, or when a write finds dirty (bit 6) clear. A read never sets dirty, and all other entry bits are preserved.
- R8: A faulting access writes nothing to memory.
- R9: With translation disabled, the response is done with rsp_paddr equal to req_vaddr, and no memory access takes place.
- R10: Writing the base register stores the value with bits [11:0] cleared. A base or enable write raises tlb_flush for exactly the following cycle.
- R11: req_ready is high only when idle, and each request gets exactly one single-cycle done or fault pulse. A memory request keeps its address, direction and data stable until mem_ready.
- R12: After reset, the outputs read: req_ready high, no memory request, no response, base 0, translation off, fault_addr 0, no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Write strobe for the directory base register |
| cfg_base_wdata | input | 32 | New directory base value |
| cfg_en_we | input | 1 | Write strobe for the translation enable bit |
| cfg_en_wdata | input | 1 | New enable value |
| user_rule | input | 1 | 0: deny user when both user flags clear; 1: when either is clear |
| cfg_base_q | output | 32 | Directory base register (low 12 bits zero) |
| paging_en | output | 1 | Translation enable bit |
| tlb_flush | output | 1 | One-cycle flush pulse after a base or enable write |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is user level |
| rsp_done | output | 1 | Translation succeeded (one cycle) |
| rsp_fault | output | 1 | Page fault (one cycle) |
| rsp_paddr | output | 32 | Physical address, valid with rsp_done |
| rsp_err | output | 3 | Fault error code, valid with rsp_fault |
| fault_addr | output | 32 | Last faulting linear address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts/completes request this cycle |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_valid and mem_ready |

## Verification
The assertions check the following on every cycle:
- the stability of a stalled memory request;
- that the walker stays unready while it walks;
- that responses are single-cycle and mutually exclusive;
- the write and user bits of every error code, against the accepted request;
- that every fault latches the accepted address;
- the flush pulse after configuration writes;
- that every write-back carries the accessed flag.

Only the bench's sweeps can show the rest. These are:
- the full permission outcome over every combination of present, user, writable, accessed and dirty flags, under both user rules;
- the exact entry values left in memory;
- the number of reads and writes per walk;
- the physical addresses produced;
- pass-through with translation off.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_RESP
    } walk_state_t;

    localparam int FLG_PRESENT  = 0;
    localparam int FLG_WRITABLE = 1;
    localparam int FLG_USER     = 2;
    localparam int FLG_ACCESSED = 5;
    localparam int FLG_DIRTY    = 6;

    localparam logic [2:0] ERR_PROT_BASE = 3'b101;
endpackage

// File: rtl/pw_ctrl_regs.sv
module pw_ctrl_regs #(
    parameter int AW    = 32,
    parameter int OFF_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          en_we,
    input  logic          en_wdata,
    output logic [AW-1:0] base_q,
    output logic          en_q,
    output logic          flush_q
);
    localparam logic [AW-1:0] LOW_MASK = (AW'(1) << OFF_W) - AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            en_q    <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= base_we | en_we;
            if (base_we) base_q <= base_wdata & ~LOW_MASK;
            if (en_we)   en_q   <= en_wdata;
        end
    end
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check (
    input  logic dir_user,
    input  logic dir_wr,
    input  logic tbl_present,
    input  logic tbl_user,
    input  logic tbl_wr,
    input  logic is_write,
    input  logic is_user,
    input  logic user_rule,
    output logic tbl_absent,
    output logic priv_deny
);
    logic user_block;
    logic write_block;

    always_comb begin
        tbl_absent  = ~tbl_present;
        user_block  = user_rule ? (~dir_user | ~tbl_user) : (~dir_user & ~tbl_user);
        write_block = is_write & (~dir_wr | ~tbl_wr);
        priv_deny   = is_user & (user_block | write_block);
    end
endmodule

// File: rtl/pw_ad_update.sv
module pw_ad_update #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] dir_ent,
    input  logic [AW-1:0] tbl_ent,
    input  logic          is_write,
    output logic          dir_stale,
    output logic [AW-1:0] dir_next,
    output logic          tbl_stale,
    output logic [AW-1:0] tbl_next
);
    import pw_pkg::*;

    always_comb begin
        dir_stale = ~dir_ent[FLG_ACCESSED];
        dir_next  = dir_ent;
        dir_next[FLG_ACCESSED] = 1'b1;

        tbl_stale = ~tbl_ent[FLG_ACCESSED] | (is_write & ~tbl_ent[FLG_DIRTY]);
        tbl_next  = tbl_ent;
        tbl_next[FLG_ACCESSED] = 1'b1;
        if (is_write) tbl_next[FLG_DIRTY] = 1'b1;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter  int IDX_W   = 10,
    localparam int OFF_W   = IDX_W + 2,
    localparam int AW      = OFF_W + 2 * IDX_W,
    localparam int FRAME_W = AW - OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_base_we,
    input  logic [AW-1:0] cfg_base_wdata,
    input  logic          cfg_en_we,
    input  logic          cfg_en_wdata,
    input  logic          user_rule,
    output logic [AW-1:0] cfg_base_q,
    output logic          paging_en,
    output logic          tlb_flush,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic          req_user,
    output logic          rsp_done,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic [2:0]    rsp_err,
    output logic [AW-1:0] fault_addr,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata
);
    import pw_pkg::*;

    walk_state_t state_q, state_d;

    logic [AW-1:0] va_q;
    logic          wr_q;
    logic          us_q;
    logic [AW-1:0] pde_q;
    logic [AW-1:0] pte_q;
    logic          res_fault_q;
    logic [2:0]    res_err_q;
    logic [AW-1:0] res_paddr_q;
    logic [AW-1:0] cr2_q;

    logic          accept;
    logic          xfer;
    logic [AW-1:0] pte_cur;
    logic          tbl_absent;
    logic          priv_deny;
    logic          dir_stale;
    logic          tbl_stale;
    logic [AW-1:0] dir_next;
    logic [AW-1:0] tbl_next;
    logic [AW-1:0] dir_ent_addr;
    logic [AW-1:0] tbl_ent_addr;
    logic [2:0]    np_code;
    logic [2:0]    prot_code;

    pw_ctrl_regs #(.AW(AW), .OFF_W(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (cfg_base_we),
        .base_wdata (cfg_base_wdata),
        .en_we      (cfg_en_we),
        .en_wdata   (cfg_en_wdata),
        .base_q     (cfg_base_q),
        .en_q       (paging_en),
        .flush_q    (tlb_flush)
    );

    assign pte_cur = (state_q == ST_TBL_RD) ? mem_rdata : pte_q;

    pw_perm_check u_perm (
        .dir_user    (pde_q[FLG_USER]),
        .dir_wr      (pde_q[FLG_WRITABLE]),
        .tbl_present (pte_cur[FLG_PRESENT]),
        .tbl_user    (pte_cur[FLG_USER]),
        .tbl_wr      (pte_cur[FLG_WRITABLE]),
        .is_write    (wr_q),
        .is_user     (us_q),
        .user_rule   (user_rule),
        .tbl_absent  (tbl_absent),
        .priv_deny   (priv_deny)
    );

    pw_ad_update #(.AW(AW)) u_ad (
        .dir_ent   (pde_q),
        .tbl_ent   (pte_cur),
        .is_write  (wr_q),
        .dir_stale (dir_stale),
        .dir_next  (dir_next),
        .tbl_stale (tbl_stale),
        .tbl_next  (tbl_next)
    );

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign xfer         = mem_valid && mem_ready;
    assign dir_ent_addr = {cfg_base_q[AW-1:OFF_W], va_q[AW-1 -: IDX_W], 2'b00};
    assign tbl_ent_addr = {pde_q[AW-1:OFF_W], va_q[OFF_W +: IDX_W], 2'b00};
    assign np_code      = {us_q, wr_q, 1'b0};
    assign prot_code    = ERR_PROT_BASE | {1'b0, wr_q, 1'b0};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = paging_en ? ST_DIR_RD : ST_RESP;
            end
            ST_DIR_RD: begin
                if (xfer) state_d = mem_rdata[FLG_PRESENT] ? ST_TBL_RD : ST_RESP;
            end
            ST_TBL_RD: begin
                if (xfer) begin
                    if (tbl_absent || priv_deny) state_d = ST_RESP;
                    else if (dir_stale)          state_d = ST_DIR_WB;
                    else if (tbl_stale)          state_d = ST_TBL_WB;
                    else                         state_d = ST_RESP;
                end
            end
            ST_DIR_WB: begin
                if (xfer) state_d = tbl_stale ? ST_TBL_WB : ST_RESP;
            end
            ST_TBL_WB: begin
                if (xfer) state_d = ST_RESP;
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            us_q        <= 1'b0;
            pde_q       <= '0;
            pte_q       <= '0;
            res_fault_q <= 1'b0;
            res_err_q   <= '0;
            res_paddr_q <= '0;
            cr2_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        va_q        <= req_vaddr;
                        wr_q        <= req_write;
                        us_q        <= req_user;
                        res_fault_q <= 1'b0;
                        res_err_q   <= '0;
                        res_paddr_q <= req_vaddr;
                    end
                end
                ST_DIR_RD: begin
                    if (xfer) begin
                        pde_q <= mem_rdata;
                        if (!mem_rdata[FLG_PRESENT]) begin
                            res_fault_q <= 1'b1;
                            res_err_q   <= np_code;
                            cr2_q       <= va_q;
                        end
                    end
                end
                ST_TBL_RD: begin
                    if (xfer) begin
                        pte_q <= mem_rdata;
                        if (tbl_absent) begin
                            res_fault_q <= 1'b1;
                            res_err_q   <= np_code;
                            cr2_q       <= va_q;
                        end else if (priv_deny) begin
                            res_fault_q <= 1'b1;
                            res_err_q   <= prot_code;
                            cr2_q       <= va_q;
                        end else begin
                            res_paddr_q <= {mem_rdata[AW-1 -: FRAME_W], va_q[OFF_W-1:0]};
                        end
                    end
                end
                ST_DIR_WB, ST_TBL_WB, ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_done  = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_DIR_RD: begin
                mem_valid = 1'b1;
                mem_addr  = dir_ent_addr;
            end
            ST_TBL_RD: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_ent_addr;
            end
            ST_DIR_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_ent_addr;
                mem_wdata = dir_next;
            end
            ST_TBL_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_ent_addr;
                mem_wdata = tbl_next;
            end
            ST_RESP: begin
                rsp_done  = ~res_fault_q;
                rsp_fault = res_fault_q;
            end
            default: ;
        endcase
    end

    assign rsp_paddr  = res_paddr_q;
    assign rsp_err    = res_err_q;
    assign fault_addr = cr2_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic          req_write,
    input logic          req_user,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic          rsp_done,
    input logic          rsp_fault,
    input logic [2:0]    rsp_err,
    input logic [AW-1:0] fault_addr,
    input logic          cfg_base_we,
    input logic          cfg_en_we,
    input logic          tlb_flush
);
    logic [AW-1:0] cap_va;
    logic          cap_wr;
    logic          cap_us;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va <= '0;
            cap_wr <= 1'b0;
            cap_us <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_va <= req_vaddr;
            cap_wr <= req_write;
            cap_us <= req_user;
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R11
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_fault)); // R11
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_fault) |=> !(rsp_done || rsp_fault)); // R11
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> fault_addr == cap_va); // R6
    AST_ERR_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_err[1] == cap_wr); // R2
    AST_NP_USER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault && !rsp_err[0] |-> rsp_err[2] == cap_us); // R2
    AST_PRIV_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault && rsp_err[0] |-> cap_us && rsp_err[2]); // R3
    AST_FLUSH_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_base_we || cfg_en_we) |=> tlb_flush); // R10
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[5]); // R7
endmodule

bind pt_walker pw_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_write   (req_write),
    .req_user    (req_user),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .rsp_done    (rsp_done),
    .rsp_fault   (rsp_fault),
    .rsp_err     (rsp_err),
    .fault_addr  (fault_addr),
    .cfg_base_we (cfg_base_we),
    .cfg_en_we   (cfg_en_we),
    .tlb_flush   (tlb_flush)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_base_we = 1'b0;
    logic [31:0] cfg_base_wdata = '0;
    logic        cfg_en_we = 1'b0;
    logic        cfg_en_wdata = 1'b0;
    logic        user_rule = 1'b0;
    logic [31:0] cfg_base_q;
    logic        paging_en;
    logic        tlb_flush;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_done;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_err;
    logic [31:0] fault_addr;
    logic        mem_valid;
    logic        mem_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .cfg_en_we(cfg_en_we), .cfg_en_wdata(cfg_en_wdata),
        .user_rule(user_rule), .cfg_base_q(cfg_base_q), .paging_en(paging_en),
        .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_err(rsp_err), .fault_addr(fault_addr), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: 64 KiB, word indexed
    logic [31:0] mem [0:16383];
    logic        stall_mode = 1'b0;
    logic        rdy_gate = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    assign mem_rdata = mem[mem_addr[15:2]];
    assign mem_ready = mem_valid & rdy_gate;

    always @(negedge clk) begin
        if (stall_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy_gate = lfsr[0];
        end else begin
            rdy_gate = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[15:2]] = mem_wdata;
                wr_cnt++;
            end else begin
                rd_cnt++;
            end
        end
    end

    task automatic summary_and_end();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung (act cycles %0d exp <= %0d)", cyc, WATCHDOG);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act 0x%08h exp 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write_base(input logic [31:0] v);
        @(negedge clk);
        cfg_base_wdata = v;
        cfg_base_we = 1'b1;
        @(negedge clk);
        cfg_base_we = 1'b0;
    endtask

    task automatic cfg_write_en(input logic v);
        @(negedge clk);
        cfg_en_wdata = v;
        cfg_en_we = 1'b1;
        @(negedge clk);
        cfg_en_we = 1'b0;
    endtask

    // issue one request; returns response fields and handshake observations
    task automatic do_req(input logic [31:0] va, input logic w, input logic u,
                          output logic got_done, output logic got_fault,
                          output logic [31:0] pa, output logic [2:0] ec,
                          output logic busy_ok, output logic after_ok);
        bit seen;
        @(negedge clk);
        req_vaddr = va;
        req_write = w;
        req_user  = u;
        req_valid = 1'b1;
        rd_cnt = 0;
        wr_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (rsp_done || rsp_fault) begin
                seen = 1'b1;
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        got_done  = seen & rsp_done;
        got_fault = seen & rsp_fault;
        pa = rsp_paddr;
        ec = rsp_err;
        @(negedge clk);
        after_ok = !rsp_done && !rsp_fault && req_ready;
    endtask

    initial begin
        logic d_o, f_o, b_o, a_o;
        logic [31:0] pa_o;
        logic [2:0]  ec_o;
        logic [31:0] exp_cr2;

        for (int k = 0; k < 16384; k++) mem[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(req_ready == 1'b1, "R12 req_ready", 32'(req_ready), 32'd1);
        chk(mem_valid == 1'b0, "R12 mem_valid", 32'(mem_valid), 32'd0);
        chk(!rsp_done && !rsp_fault, "R12 response", {30'd0, rsp_done, rsp_fault}, 32'd0);
        chk(cfg_base_q == 32'd0, "R12 base", cfg_base_q, 32'd0);
        chk(paging_en == 1'b0, "R12 enable", 32'(paging_en), 32'd0);
        chk(fault_addr == 32'd0, "R12 fault_addr", fault_addr, 32'd0);
        chk(tlb_flush == 1'b0, "R12 flush", 32'(tlb_flush), 32'd0);
        exp_cr2 = 32'd0;

        // R9: pass-through while disabled
        for (int k = 0; k < 8; k++) begin
            logic [31:0] va;
            va = 32'h9E37_79B9 * (k + 1);
            do_req(va, k[0], k[1], d_o, f_o, pa_o, ec_o, b_o, a_o);
            chk(d_o && !f_o, "R9 done when disabled", {30'd0, d_o, f_o}, 32'd2);
            chk(pa_o == va, "R9 paddr equals vaddr", pa_o, va);
            chk(rd_cnt == 0 && wr_cnt == 0, "R9 no memory access", 32'(rd_cnt + wr_cnt), 32'd0);
            chk(a_o, "R11 single pulse then ready", 32'(a_o), 32'd1);
        end

        // R10: base write clears low bits and pulses flush
        @(negedge clk);
        cfg_base_wdata = 32'h1234_5ABC;
        cfg_base_we = 1'b1;
        @(negedge clk);
        cfg_base_we = 1'b0;
        chk(cfg_base_q == 32'h1234_5000, "R10 base low bits cleared", cfg_base_q, 32'h1234_5000);
        chk(tlb_flush == 1'b1, "R10 flush pulse", 32'(tlb_flush), 32'd1);
        @(negedge clk);
        chk(tlb_flush == 1'b0, "R10 flush one cycle", 32'(tlb_flush), 32'd0);
        cfg_write_base(32'h0000_1FFF);
        chk(cfg_base_q == 32'h0000_1000, "R10 base value", cfg_base_q, 32'h0000_1000);
        @(negedge clk);
        cfg_en_wdata = 1'b1;
        cfg_en_we = 1'b1;
        @(negedge clk);
        cfg_en_we = 1'b0;
        chk(tlb_flush == 1'b1 && paging_en == 1'b1, "R10 enable write flush", {30'd0, tlb_flush, paging_en}, 32'd3);

        // R1..R8, R11: near-exhaustive sweep over entry flags, access kind and rule
        for (int i = 0; i < 4096; i++) begin
            int d, t, off, fr;
            logic [31:0] pde, pte, va, pfr, exp_pde, exp_pte, exp_pa;
            logic [2:0] exp_ec;
            logic w, u, rule, exp_fault, deny, ublk;
            int exp_rd, exp_wr;

            d   = (i * 37 + 3) % 1024;
            t   = (i * 91 + 5) % 1024;
            off = (i * 13) % 4096;
            fr  = 2 + (i % 4);
            pfr = (32'(i) * 32'd7 + 32'h12345) & 32'hFFFFF;
            w    = i[9];
            u    = i[10];
            rule = i[11];
            pde = (32'(fr) << 12) | 32'h0000_0998 |
                  {26'd0, i[3], 2'b00, i[2], i[1], i[0]};
            pte = (pfr << 12) | 32'h0000_0518 |
                  {25'd0, i[8], i[7], 2'b00, i[6], i[5], i[4]};
            mem[32'h400 + 32'(d)]        = pde;
            mem[32'(fr) * 32'h400 + 32'(t)] = pte;
            va = {d[9:0], t[9:0], off[11:0]};
            stall_mode = (i % 3 == 0);
            user_rule = rule;

            // expected outcome from the requirements
            exp_pde = pde;
            exp_pte = pte;
            exp_pa  = 32'd0;
            exp_ec  = 3'd0;
            exp_wr  = 0;
            if (!pde[0]) begin
                exp_fault = 1'b1; exp_ec = {u, w, 1'b0}; exp_rd = 1;
            end else if (!pte[0]) begin
                exp_fault = 1'b1; exp_ec = {u, w, 1'b0}; exp_rd = 2;
            end else begin
                exp_rd = 2;
                ublk = rule ? (!pde[2] || !pte[2]) : (!pde[2] && !pte[2]);
                deny = u && (ublk || (w && (!pde[1] || !pte[1])));
                if (deny) begin
                    exp_fault = 1'b1; exp_ec = {1'b1, w, 1'b1};
                end else begin
                    exp_fault = 1'b0;
                    exp_pa = {pte[31:12], off[11:0]};
                    if (!pde[5]) exp_wr++;
                    if (!pte[5] || (w && !pte[6])) exp_wr++;
                    exp_pde = pde | 32'h20;
                    exp_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
                end
            end
            if (exp_fault) exp_cr2 = va;

            do_req(va, w, u, d_o, f_o, pa_o, ec_o, b_o, a_o);
            stall_mode = 1'b0;

            if (exp_fault) begin
                chk(f_o && !d_o, "R2/R3/R4/R5 fault expected", {30'd0, d_o, f_o}, 32'd1);
                chk(ec_o == exp_ec, exp_ec[0] ? "R3 privilege error code" : "R2 not-present error code",
                    32'(ec_o), 32'(exp_ec));
                chk(mem[32'h400 + 32'(d)] == pde && mem[32'(fr) * 32'h400 + 32'(t)] == pte,
                    "R8 entries untouched on fault", mem[32'(fr) * 32'h400 + 32'(t)], pte);
            end else begin
                chk(d_o && !f_o, "R3/R4/R5 access allowed", {30'd0, d_o, f_o}, 32'd2);
                chk(pa_o == exp_pa, "R1 physical address", pa_o, exp_pa);
                chk(mem[32'h400 + 32'(d)] == exp_pde, "R7 directory write-back",
                    mem[32'h400 + 32'(d)], exp_pde);
                chk(mem[32'(fr) * 32'h400 + 32'(t)] == exp_pte, "R7 table write-back",
                    mem[32'(fr) * 32'h400 + 32'(t)], exp_pte);
            end
            chk(fault_addr == exp_cr2, "R6 fault address register", fault_addr, exp_cr2);
            chk(rd_cnt == exp_rd, "R2 memory read count", 32'(rd_cnt), 32'(exp_rd));
            chk(wr_cnt == exp_wr, "R8 write-back count", 32'(wr_cnt), 32'(exp_wr));
            chk(b_o && a_o, "R11 busy while walking, single pulse", {30'd0, b_o, a_o}, 32'd3);
        end

        // R9: disable again; memory must stay untouched
        cfg_write_en(1'b0);
        do_req(32'h0040_3007, 1'b1, 1'b1, d_o, f_o, pa_o, ec_o, b_o, a_o);
        chk(d_o && pa_o == 32'h0040_3007, "R9 pass-through after disable", pa_o, 32'h0040_3007);
        chk(rd_cnt == 0 && wr_cnt == 0, "R9 no access after disable", 32'(rd_cnt + wr_cnt), 32'd0);
        chk(fault_addr == exp_cr2, "R6 fault address held", fault_addr, exp_cr2);

        summary_and_end();
    end
endmodule